// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a watchdog peripheral reached over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Software sets a reload constant and turns the watchdog on. It must then keep proving it is alive by writing a two-word key to the feed register: first 0xAA, then 0x55. A correct key reloads a down-counter from the constant. The counter steps once every four clocks. If the counter runs out, or if a feed write breaks the key, the watchdog expires. On expiry it sets two status flags and raises an interrupt line. If hardware reset is selected, it also drives a fixed-length reset pulse.

Software cannot switch the watchdog off. Only the synchronous block reset input `blk_rst` returns it to the disabled state.

The control flow is built from two state machines.

The feed checker has two states, FEED_IDLE and FEED_HALF:
- FEED_IDLE goes to FEED_HALF on a write of 0xAA.
- FEED_HALF goes back to FEED_IDLE on any feed write. A write of 0x55 is a good feed; any other value is a bad feed.
- In FEED_IDLE, a feed write of any value other than 0xAA is a bad feed and the state stays in FEED_IDLE.

The timer core has four states: CORE_OFF, CORE_ARMED, CORE_RUN and CORE_EXPIRED:
- CORE_OFF goes to CORE_ARMED once enable is set.
- A good feed sends any enabled state to CORE_RUN.
- Running out in CORE_RUN sends it to CORE_EXPIRED.
- A bad feed sends any enabled state to CORE_EXPIRED.

Top module: `feedwd_top`

## Requirements
- R1: Registers decode on exact byte addresses: 0x0 is mode, 0x4 is the reload constant, 0x8 is the feed register (write-only, reads 0) and 0xC is the live counter (read-only). Mode bits are: bit 0 enable, bit 1 hardware-reset select, bit 2 timeout flag, bit 3 interrupt flag. All other read bits are 0.
- R2: The reload constant resets to 0xFF. A write below 0xFF stores 0xFF, a write above 0x7FFFFFFF stores 0x7FFFFFFF, and any other value is stored unchanged.
- R3: Writing 1 to mode bit 0 enables the watchdog. Writing 0 to that bit leaves it set.
- R4: While disabled, feed writes have no effect: no flag is set, `irq` stays low and `reset_out` stays low.
- R5: After enable, the counter stays at 0 and never expires until the first good feed.
- R6: A good feed is a write of 0xAA followed by a feed write of 0x55. It loads the counter from the constant as it stands at that moment, so a constant written while the counter runs only takes effect at the next good feed.
- R7: After a good feed written at clock edge E, the counter steps down by one every 4 clocks. Expiry occurs at edge E + 4 × (constant + 1).
- R8: While enabled, a feed write that breaks the key causes expiry at the edge that takes the write. A break is either a first word other than 0xAA, or a second word other than 0x55.
- R9: Expiry sets mode bit 2. A mode write with bit 2 at 0 clears it; a mode write with bit 2 at 1 leaves it set.
- R10: Expiry sets mode bit 3. No bus write clears it. `irq` equals this bit.
- R11: If mode bit 1 is set when expiry occurs, `reset_out` goes high for exactly 16 clocks starting after the expiry edge. If bit 1 is clear, `reset_out` stays low.
- R12: After expiry the counter reads 0 until the next good feed.
- R13: `blk_rst` returns all registers, both flags and both outputs to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| blk_rst | input | 1 | Synchronous block reset, active high |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt, follows mode bit 3 |
| reset_out | output | 1 | System reset pulse on expiry |

## Verification
The bound checker watches the following on every clock:
- enable and the interrupt line never fall outside a block reset;
- the stored constant always stays inside its legal range;
- a disabled block never raises `irq` or `reset_out`;
- a rising edge on `irq` always comes with the timeout flag;
- a reset pulse only starts when hardware reset was selected.

Other behaviour can only be shown by the bench's scenarios:
- the exact expiry cycle after a feed;
- the idle counter before the first feed;
- late pickup of a new constant;
- both kinds of broken key;
- the 16-clock pulse length;
- clearing of the timeout flag.

// File: rtl/feedwd_pkg.sv
package feedwd_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic {
        FEED_IDLE,
        FEED_HALF
    } feed_st_t;

    typedef enum logic [1:0] {
        CORE_OFF,
        CORE_ARMED,
        CORE_RUN,
        CORE_EXPIRED
    } core_st_t;

    // byte offsets of the register slots
    localparam int OFF_MODE  = 'h0;
    localparam int OFF_CONST = 'h4;
    localparam int OFF_FEED  = 'h8;
    localparam int OFF_COUNT = 'hC;

    // mode register bit positions (software decodes these)
    localparam int MB_EN    = 0;
    localparam int MB_HWRST = 1;
    localparam int MB_TOF   = 2;
    localparam int MB_INT   = 3;
endpackage

// File: rtl/feedwd_regs.sv
module feedwd_regs #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 31,
    parameter int MIN_CONST = 255
) (
    input  logic              clk,
    input  logic              blk_rst,
    input  logic              wr_mode,
    input  logic              wr_const,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire_evt,
    output logic              en_q,
    output logic              hwrst_q,
    output logic              tof_q,
    output logic              int_q,
    output logic [CNT_W-1:0]  const_q
);
    timeunit 1ns;
    timeprecision 100ps;
    import feedwd_pkg::*;

    localparam logic [DATA_W-1:0] LO_W = DATA_W'(MIN_CONST);
    localparam logic [DATA_W-1:0] HI_W = DATA_W'({CNT_W{1'b1}});

    // enable is sticky; flags follow their own set/clear rules
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            en_q    <= 1'b0;
            hwrst_q <= 1'b0;
            tof_q   <= 1'b0;
            int_q   <= 1'b0;
        end else begin
            if (wr_mode && wdata[MB_EN]) begin
                en_q <= 1'b1;
            end
            if (wr_mode) begin
                hwrst_q <= wdata[MB_HWRST];
            end
            if (expire_evt) begin
                tof_q <= 1'b1;
            end else if (wr_mode && !wdata[MB_TOF]) begin
                tof_q <= 1'b0;
            end
            if (expire_evt) begin
                int_q <= 1'b1;
            end
        end
    end

    // reload constant with clamping on both ends
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            const_q <= CNT_W'(MIN_CONST);
        end else if (wr_const) begin
            if (wdata < LO_W) begin
                const_q <= CNT_W'(MIN_CONST);
            end else if (wdata > HI_W) begin
                const_q <= {CNT_W{1'b1}};
            end else begin
                const_q <= wdata[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/feedwd_feed_fsm.sv
module feedwd_feed_fsm #(
    parameter int DATA_W    = 32,
    parameter int KEY_OPEN  = 'hAA,
    parameter int KEY_CLOSE = 'h55
) (
    input  logic              clk,
    input  logic              blk_rst,
    input  logic              enable,
    input  logic              feed_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              feed_ok,
    output logic              feed_bad
);
    timeunit 1ns;
    timeprecision 100ps;
    import feedwd_pkg::*;

    localparam logic [DATA_W-1:0] OPEN_W  = DATA_W'(KEY_OPEN);
    localparam logic [DATA_W-1:0] CLOSE_W = DATA_W'(KEY_CLOSE);

    feed_st_t st_q, st_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            st_q <= FEED_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state and verdicts
    always_comb begin
        st_nxt   = st_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (enable && feed_wr) begin
            unique case (st_q)
                FEED_IDLE: begin
                    if (wdata == OPEN_W) begin
                        st_nxt = FEED_HALF;
                    end else begin
                        feed_bad = 1'b1;
                    end
                end
                FEED_HALF: begin
                    st_nxt = FEED_IDLE;
                    if (wdata == CLOSE_W) begin
                        feed_ok = 1'b1;
                    end else begin
                        feed_bad = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/feedwd_core.sv
module feedwd_core #(
    parameter int CNT_W    = 31,
    parameter int STEP_DIV = 4
) (
    input  logic             clk,
    input  logic             blk_rst,
    input  logic             enable,
    input  logic             feed_ok,
    input  logic             feed_bad,
    input  logic [CNT_W-1:0] const_q,
    output logic [CNT_W-1:0] count_q,
    output logic             expire_evt
);
    timeunit 1ns;
    timeprecision 100ps;
    import feedwd_pkg::*;

    localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_DIV - 1);

    core_st_t st_q, st_nxt;
    logic [PRE_W-1:0] pre_q;
    logic tick;

    assign tick = (pre_q == PRE_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            st_q <= CORE_OFF;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt     = st_q;
        expire_evt = 1'b0;
        unique case (st_q)
            CORE_OFF:     st_nxt = enable ? CORE_ARMED : CORE_OFF;
            CORE_ARMED:   st_nxt = CORE_ARMED;
            CORE_RUN: begin
                if (tick && (count_q == '0)) begin
                    expire_evt = 1'b1;
                    st_nxt     = CORE_EXPIRED;
                end
            end
            CORE_EXPIRED: st_nxt = CORE_EXPIRED;
        endcase
        if (feed_ok) begin
            expire_evt = 1'b0;
            st_nxt     = CORE_RUN;
        end
        if (feed_bad) begin
            expire_evt = 1'b1;
            st_nxt     = CORE_EXPIRED;
        end
    end

    // counter and prescaler
    always_ff @(posedge clk) begin
        if (blk_rst) begin
            count_q <= '0;
            pre_q   <= '0;
        end else if (feed_ok) begin
            count_q <= const_q;
            pre_q   <= '0;
        end else if (expire_evt) begin
            count_q <= '0;
            pre_q   <= '0;
        end else if (st_q == CORE_RUN) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                count_q <= count_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/feedwd_pulse.sv
module feedwd_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic blk_rst,
    input  logic fire,
    output logic pulse
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/feedwd_top.sv
module feedwd_top #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 31,
    parameter int MIN_CONST = 255,
    parameter int STEP_DIV  = 4,
    parameter int PULSE_LEN = 16,
    parameter int KEY_OPEN  = 'hAA,
    parameter int KEY_CLOSE = 'h55
) (
    input  logic              clk,
    input  logic              blk_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              reset_out
);
    timeunit 1ns;
    timeprecision 100ps;
    import feedwd_pkg::*;

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(OFF_CONST);
    localparam logic [ADDR_W-1:0] A_FEED  = ADDR_W'(OFF_FEED);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);

    logic             wr_mode, wr_const, wr_feed;
    logic             en_q, hwrst_q, tof_q, int_q;
    logic [CNT_W-1:0] const_q, count_q;
    logic             feed_ok, feed_bad, expire_evt;

    assign wr_mode  = bus_wr && (bus_addr == A_MODE);
    assign wr_const = bus_wr && (bus_addr == A_CONST);
    assign wr_feed  = bus_wr && (bus_addr == A_FEED);

    feedwd_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_CONST(MIN_CONST)
    ) u_regs (
        .clk(clk), .blk_rst(blk_rst), .wr_mode(wr_mode), .wr_const(wr_const),
        .wdata(bus_wdata), .expire_evt(expire_evt), .en_q(en_q),
        .hwrst_q(hwrst_q), .tof_q(tof_q), .int_q(int_q), .const_q(const_q)
    );

    feedwd_feed_fsm #(
        .DATA_W(DATA_W), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
    ) u_feed (
        .clk(clk), .blk_rst(blk_rst), .enable(en_q), .feed_wr(wr_feed),
        .wdata(bus_wdata), .feed_ok(feed_ok), .feed_bad(feed_bad)
    );

    feedwd_core #(
        .CNT_W(CNT_W), .STEP_DIV(STEP_DIV)
    ) u_core (
        .clk(clk), .blk_rst(blk_rst), .enable(en_q), .feed_ok(feed_ok),
        .feed_bad(feed_bad), .const_q(const_q), .count_q(count_q),
        .expire_evt(expire_evt)
    );

    feedwd_pulse #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk(clk), .blk_rst(blk_rst), .fire(expire_evt && hwrst_q),
        .pulse(reset_out)
    );

    assign irq = int_q;

    // read mux; feed slot and unmapped addresses read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE) begin
            bus_rdata[MB_EN]    = en_q;
            bus_rdata[MB_HWRST] = hwrst_q;
            bus_rdata[MB_TOF]   = tof_q;
            bus_rdata[MB_INT]   = int_q;
        end else if (bus_addr == A_CONST) begin
            bus_rdata = DATA_W'(const_q);
        end else if (bus_addr == A_COUNT) begin
            bus_rdata = DATA_W'(count_q);
        end
    end
endmodule

// File: rtl/feedwd_chk.sv
module feedwd_chk #(
    parameter int CNT_W     = 31,
    parameter int MIN_CONST = 255
) (
    input logic             clk,
    input logic             blk_rst,
    input logic             en,
    input logic             hwrst,
    input logic             tof,
    input logic             irq,
    input logic             reset_out,
    input logic [CNT_W-1:0] const_q
);
    timeunit 1ns;
    timeprecision 100ps;

    // R3
    en_sticky_chk: assert property (@(posedge clk) disable iff (blk_rst)
        en |=> en);

    // R2
    const_range_chk: assert property (@(posedge clk) disable iff (blk_rst)
        const_q >= CNT_W'(MIN_CONST));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (blk_rst)
        !en |-> (!irq && !reset_out));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (blk_rst)
        irq |=> irq);

    // R9
    irq_with_tof_chk: assert property (@(posedge clk) disable iff (blk_rst)
        $rose(irq) |-> tof);

    // R11
    pulse_gated_chk: assert property (@(posedge clk) disable iff (blk_rst)
        $rose(reset_out) |-> $past(hwrst));
endmodule

bind feedwd_top feedwd_chk #(
    .CNT_W(CNT_W), .MIN_CONST(MIN_CONST)
) u_chk (
    .clk(clk), .blk_rst(blk_rst), .en(en_q), .hwrst(hwrst_q), .tof(tof_q),
    .irq(irq), .reset_out(reset_out), .const_q(const_q)
);

// File: tb/feedwd_top_tb.sv
module feedwd_top_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [3:0] A_MODE  = 4'h0;
    localparam logic [3:0] A_CONST = 4'h4;
    localparam logic [3:0] A_FEED  = 4'h8;
    localparam logic [3:0] A_COUNT = 4'hC;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_RST = 2;

    logic        clk = 1'b0;
    logic        blk_rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, reset_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;
    event smp_ev;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    feedwd_top u_dut (
        .clk(clk), .blk_rst(blk_rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .reset_out(reset_out)
    );

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // driver side of the scoreboard: push the expectation, then request a sample
    task automatic expect_at(input int kind, input logic [3:0] a,
                             input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        -> smp_ev;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic good_feed();
        bus_write(A_FEED, 32'hAA);
        bus_write(A_FEED, 32'h55);
    endtask

    // monitor side: pop and compare mid low phase
    initial begin
        forever begin
            logic [31:0] act;
            @(smp_ev);
            #1;
            cur = sb_q.pop_front();
            unique case (cur.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'b0, irq};
                default: act = {31'b0, reset_out};
            endcase
            n_chk++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        blk_rst = 1'b0;

        // R1 R13 reset state
        expect_at(K_RD, A_MODE, 32'h0, "R13 mode after reset");
        expect_at(K_RD, A_CONST, 32'hFF, "R2 const after reset");
        expect_at(K_RD, A_COUNT, 32'h0, "R1 count after reset");
        expect_at(K_IRQ, A_MODE, 32'h0, "R13 irq after reset");
        expect_at(K_RST, A_MODE, 32'h0, "R13 reset_out after reset");

        // R2 clamping
        bus_write(A_CONST, 32'h10);
        expect_at(K_RD, A_CONST, 32'hFF, "R2 low clamp");
        bus_write(A_CONST, 32'hFFFF_FFFF);
        expect_at(K_RD, A_CONST, 32'h7FFF_FFFF, "R2 high clamp");
        bus_write(A_CONST, 32'h100);
        expect_at(K_RD, A_CONST, 32'h100, "R2 in range");
        bus_write(A_CONST, 32'hFF);

        // R4 feed while disabled is ignored
        bus_write(A_FEED, 32'h12);
        expect_at(K_IRQ, A_MODE, 32'h0, "R4 irq after feed while off");
        expect_at(K_RD, A_MODE, 32'h0, "R4 no flags while off");
        expect_at(K_RD, A_FEED, 32'h0, "R1 feed reads zero");

        // R3 enable sticky
        bus_write(A_MODE, 32'h1);
        expect_at(K_RD, A_MODE, 32'h1, "R3 enabled");
        bus_write(A_MODE, 32'h0);
        expect_at(K_RD, A_MODE, 32'h1, "R3 enable ignores zero");

        // R5 armed, no counting before first feed
        wait_clk(1100);
        expect_at(K_IRQ, A_MODE, 32'h0, "R5 no expiry before feed");
        expect_at(K_RD, A_COUNT, 32'h0, "R5 count idle");

        // R6 R7 feed and exact period, constant 0xFF
        good_feed();
        expect_at(K_RD, A_COUNT, 32'hFF, "R6 reload");
        wait_clk(1024 - 3);
        expect_at(K_IRQ, A_MODE, 32'h0, "R7 one cycle before expiry");
        expect_at(K_IRQ, A_MODE, 32'h1, "R7 expiry cycle");
        expect_at(K_RD, A_MODE, 32'hD, "R9 R10 flags on expiry");
        expect_at(K_RST, A_MODE, 32'h0, "R11 no pulse without hw select");

        // R9 R10 flag clearing rules
        bus_write(A_MODE, 32'h4);
        expect_at(K_RD, A_MODE, 32'hD, "R9 writing one keeps flag");
        bus_write(A_MODE, 32'h0);
        expect_at(K_RD, A_MODE, 32'h9, "R9 R10 flag clear, int stays");
        expect_at(K_IRQ, A_MODE, 32'h1, "R10 irq stays");

        // R12 counter holds at zero
        wait_clk(20);
        expect_at(K_RD, A_COUNT, 32'h0, "R12 count held at zero");

        // R8 R11 broken second word with hw reset selected
        bus_write(A_MODE, 32'h3);
        expect_at(K_RD, A_MODE, 32'hB, "R1 mode with hw select");
        good_feed();
        expect_at(K_RST, A_MODE, 32'h0, "R11 no pulse yet");
        bus_write(A_FEED, 32'hAA);
        bus_write(A_FEED, 32'h33);
        expect_at(K_RST, A_MODE, 32'h1, "R11 pulse starts");
        wait_clk(13);
        expect_at(K_RST, A_MODE, 32'h1, "R11 pulse last cycle");
        expect_at(K_RST, A_MODE, 32'h0, "R11 pulse ended");
        expect_at(K_RD, A_MODE, 32'hF, "R8 bad second word expires");
        expect_at(K_RD, A_COUNT, 32'h0, "R12 count zero after bad feed");

        // R8 broken first word
        bus_write(A_MODE, 32'h1);
        good_feed();
        expect_at(K_RD, A_MODE, 32'h9, "R9 cleared before test");
        bus_write(A_FEED, 32'h55);
        expect_at(K_RD, A_MODE, 32'hD, "R8 bad first word expires");

        // R6 new constant only at next feed
        bus_write(A_CONST, 32'h120);
        good_feed();
        bus_write(A_CONST, 32'h180);
        expect_at(K_RD, A_COUNT, 32'h120, "R6 old constant still counting");
        good_feed();
        expect_at(K_RD, A_COUNT, 32'h180, "R6 new constant at next feed");
        wait_clk(8);
        expect_at(K_RD, A_COUNT, 32'h17E, "R7 two steps in eight clocks");

        // R13 block reset
        @(negedge clk);
        blk_rst = 1'b1;
        wait_clk(2);
        blk_rst = 1'b0;
        expect_at(K_RD, A_MODE, 32'h0, "R13 mode cleared");
        expect_at(K_RD, A_CONST, 32'hFF, "R13 const restored");
        expect_at(K_IRQ, A_MODE, 32'h0, "R13 irq cleared");
        expect_at(K_RD, A_COUNT, 32'h0, "R13 count cleared");

        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule